// File: doc/BRIEF.md
# Bidirectional Barrel Shifter with Carry and Overflow

This block shifts a 32-bit word by 0 to 31 positions in either direction within a single combinational path. It contains only one shift network, which always moves bits toward the most significant end. For a right shift, a row of 2:1 multiplexers mirrors the operand's bit order before the network, and a second row mirrors the result back afterwards. The network is logarithmic. There is one stage per bit of the shift amount, and each stage either passes its word through or moves it by a power-of-two distance.

Alongside the result, the block reports the last bit pushed off the end of the word as a carry. It also raises a signed-overflow flag for left shifts. Right shifts can be logical, with zero fill, or arithmetic, which fills from the original sign bit. The fill value is fed into the mirrored network, so no separate sign-extension logic is needed. The block holds no state and uses no clock.

Top module: `bidir_shifter`

## Requirements
- R1: With `dir_right_i`=0, `result_o` equals `data_i` shifted toward the MSB by `amt_i`, with the vacated low bits set to 0.
- R2: With `dir_right_i`=1 and `arith_i`=0, `result_o` equals `data_i` shifted toward the LSB by `amt_i`, with the vacated high bits set to 0.
- R3: With `dir_right_i`=1 and `arith_i`=1, the vacated high bits take the value of `data_i[31]`. This is the signed right shift.
- R4: With `dir_right_i`=0, `arith_i` changes none of the three outputs.
- R5: When `amt_i`=0, `result_o` equals `data_i` and `carry_o` is 0 in both directions.
- R6: For a left shift by n>0, `carry_o` equals `data_i[32-n]`.
- R7: For a right shift by n>0, `carry_o` equals `data_i[n-1]` in both fill modes.
- R8: For a left shift, `ovf_o` is 1 exactly when a bit shifted out, or the new bit 31, differs from the original `data_i[31]`.
- R9: For a right shift, `ovf_o` is 0.
- R10: The outputs follow a change of any input in the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Operand word |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| dir_right_i | input | 1 | 1 selects a right shift, 0 a left shift |
| arith_i | input | 1 | 1 selects sign fill on right shifts |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Last bit shifted out, 0 when nothing is shifted |
| ovf_o | output | 1 | Signed overflow of a left shift |

## Verification
The block has no state, so any internal fault appears at the ports in the same time step that the inputs settle. A stuck stage select corrupts every shift whose amount has that bit set, and a wrong power-of-two distance shows up the same way. A broken mirror row corrupts only right shifts and shows as reversed or misplaced bits. A wrong carry or overflow tap appears only for particular amounts and sign patterns, which is why every amount is swept in both directions against patterns whose upper bits vary.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned DEF_WIDTH = 32;
endpackage

// File: rtl/bit_rev_mux.sv
module bit_rev_mux #(
  parameter int unsigned WIDTH = shift_pkg::DEF_WIDTH
) (
  input  logic             rev_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign d_o[i] = rev_i ? d_i[WIDTH-1-i] : d_i[i];
  end
endmodule

// File: rtl/lsh_stage.sv
module lsh_stage #(
  parameter int unsigned WIDTH = shift_pkg::DEF_WIDTH,
  parameter int unsigned DIST  = 1
) (
  input  logic             en_i,
  input  logic             fill_i,
  input  logic             sign_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] d_o,
  output logic             carry_o,
  output logic             ovf_o
);
  always_comb begin
    if (en_i) begin
      d_o     = {d_i[WIDTH-1-DIST:0], {DIST{fill_i}}};
      carry_o = d_i[WIDTH-DIST];
      // dropped bits plus new top bit must all match original sign
      ovf_o   = ovf_i | (d_i[WIDTH-1:WIDTH-1-DIST] != {(DIST+1){sign_i}});
    end else begin
      d_o     = d_i;
      carry_o = carry_i;
      ovf_o   = ovf_i;
    end
  end
endmodule

// File: rtl/lsh_core.sv
module lsh_core #(
  parameter int unsigned WIDTH = shift_pkg::DEF_WIDTH,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  input  logic             sign_i,
  output logic [WIDTH-1:0] d_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] d_q [AMT_W+1];
  logic             c_q [AMT_W+1];
  logic             v_q [AMT_W+1];

  assign d_q[0] = d_i;
  assign c_q[0] = 1'b0;
  assign v_q[0] = 1'b0;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    lsh_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .en_i   (amt_i[k]),
      .fill_i (fill_i),
      .sign_i (sign_i),
      .d_i    (d_q[k]),
      .carry_i(c_q[k]),
      .ovf_i  (v_q[k]),
      .d_o    (d_q[k+1]),
      .carry_o(c_q[k+1]),
      .ovf_o  (v_q[k+1])
    );
  end

  assign d_o     = d_q[AMT_W];
  assign carry_o = c_q[AMT_W];
  assign ovf_o   = v_q[AMT_W];
endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter #(
  parameter int unsigned WIDTH = shift_pkg::DEF_WIDTH,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_right_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] pre_rev, core_out;
  logic             core_carry, core_ovf, fill;

  // sign fill only for arithmetic right shifts
  assign fill = dir_right_i & arith_i & data_i[WIDTH-1];

  bit_rev_mux #(.WIDTH(WIDTH)) u_rev_in (
    .rev_i(dir_right_i),
    .d_i  (data_i),
    .d_o  (pre_rev)
  );

  lsh_core #(.WIDTH(WIDTH)) u_core (
    .d_i    (pre_rev),
    .amt_i  (amt_i),
    .fill_i (fill),
    .sign_i (data_i[WIDTH-1]),
    .d_o    (core_out),
    .carry_o(core_carry),
    .ovf_o  (core_ovf)
  );

  bit_rev_mux #(.WIDTH(WIDTH)) u_rev_out (
    .rev_i(dir_right_i),
    .d_i  (core_out),
    .d_o  (result_o)
  );

  assign carry_o = core_carry;
  assign ovf_o   = core_ovf & ~dir_right_i;
endmodule

// File: rtl/bidir_shifter_chk.sv
module bidir_shifter_chk #(
  parameter int unsigned WIDTH = shift_pkg::DEF_WIDTH,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             dir_right_i,
  input logic             arith_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o
);
  logic [WIDTH-1:0] keep_mask;
  logic             known;

  always_comb begin
    keep_mask = {WIDTH{1'b1}} >> amt_i;
    known = !$isunknown({data_i, amt_i, dir_right_i, arith_i, result_o, carry_o, ovf_o});
    if (known) begin
      // R5
      zero_amt_chk: assert (amt_i != '0 || (result_o == data_i && !carry_o));
      // R9
      no_overflow_chk: assert (!dir_right_i || !ovf_o);
      // R1
      left_fill_chk: assert (dir_right_i || (result_o & ~({WIDTH{1'b1}} << amt_i)) == '0);
      // R3
      sign_fill_chk: assert (!(dir_right_i && arith_i) ||
                             (result_o & ~keep_mask) == (data_i[WIDTH-1] ? ~keep_mask : '0));
      // R2
      zero_fill_chk: assert (!(dir_right_i && !arith_i) || (result_o & ~keep_mask) == '0);
    end
  end
endmodule

bind bidir_shifter bidir_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .data_i     (data_i),
  .amt_i      (amt_i),
  .dir_right_i(dir_right_i),
  .arith_i    (arith_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o)
);

// File: tb/bidir_shifter_tb.sv
module bidir_shifter_tb;
  localparam int W = 32;
  localparam int NPAT = 10;
  localparam logic [W-1:0] PATS [NPAT] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h4000_0000,
    32'h0001_0000, 32'hDEAD_BEEF, 32'h1234_5678, 32'h7FFF_FFFF, 32'hA5C3_0F96
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [4:0]   amt_i = '0;
  logic         dir_right_i = 1'b0, arith_i = 1'b0;
  logic [W-1:0] result_o;
  logic         carry_o, ovf_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bidir_shifter u_dut (
    .data_i(data_i), .amt_i(amt_i), .dir_right_i(dir_right_i), .arith_i(arith_i),
    .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s d=%h n=%0d r=%b a=%b act=%h exp=%h", req, data_i, amt_i, dir_right_i, arith_i, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int n, input bit r, input bit a);
    @(negedge clk);
    data_i = d; amt_i = 5'(n); dir_right_i = r; arith_i = a;
    #1;
  endtask

  task automatic check_all();
    logic [W-1:0] exp_res;
    logic exp_c, exp_v;
    int n;
    n = int'(amt_i);
    if (!dir_right_i) exp_res = data_i << n;
    else if (arith_i) exp_res = $unsigned($signed(data_i) >>> n);
    else exp_res = data_i >> n;
    exp_c = (n == 0) ? 1'b0 : (dir_right_i ? data_i[n-1] : data_i[W-n]);
    exp_v = !dir_right_i && (($signed(data_i << n) >>> n) != $signed(data_i));
    if (!dir_right_i) chk(result_o == exp_res, "R1", result_o, exp_res);
    else if (arith_i) chk(result_o == exp_res, "R3", result_o, exp_res);
    else chk(result_o == exp_res, "R2", result_o, exp_res);
    if (n == 0) chk(carry_o == 1'b0 && result_o == data_i, "R5", {31'd0, carry_o}, 32'd0);
    else if (dir_right_i) chk(carry_o == exp_c, "R7", {31'd0, carry_o}, {31'd0, exp_c});
    else chk(carry_o == exp_c, "R6", {31'd0, carry_o}, {31'd0, exp_c});
    if (dir_right_i) chk(ovf_o == 1'b0, "R9", {31'd0, ovf_o}, 32'd0);
    else chk(ovf_o == exp_v, "R8", {31'd0, ovf_o}, {31'd0, exp_v});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r0;
    logic c0, v0;
    repeat (3) @(posedge clk);
    #1;
    // reset-time state: zero inputs give zero outputs
    chk(result_o == '0 && !carry_o && !ovf_o, "R5", result_o, '0);
    rst_ni = 1'b1;

    for (int p = 0; p < NPAT; p++)
      for (int n = 0; n < W; n++)
        for (int m = 0; m < 3; m++) begin
          apply(PATS[p], n, m != 0, m == 2);
          check_all();
        end

    // R4: arith select has no effect on left shifts
    for (int n = 0; n < W; n += 5) begin
      apply(32'hC001_F00D, n, 1'b0, 1'b0);
      r0 = result_o; c0 = carry_o; v0 = ovf_o;
      apply(32'hC001_F00D, n, 1'b0, 1'b1);
      chk(result_o == r0 && carry_o == c0 && ovf_o == v0, "R4", result_o, r0);
    end

    // R8 corners: sign-preserving shift vs. sign-changing shift
    apply(32'hFFFF_FFFF, 31, 1'b0, 1'b0);
    chk(ovf_o == 1'b0, "R8", {31'd0, ovf_o}, 32'd0);
    apply(32'h4000_0000, 1, 1'b0, 1'b0);
    chk(ovf_o == 1'b1, "R8", {31'd0, ovf_o}, 32'd1);

    // R10: output follows an input change mid-cycle, no edge
    @(posedge clk);
    #1;
    data_i = 32'h0000_00F0; amt_i = 5'd4; dir_right_i = 1'b1; arith_i = 1'b0;
    #0.5;
    chk(result_o == 32'h0000_000F, "R10", result_o, 32'h0000_000F);
    data_i = 32'h8000_0000; arith_i = 1'b1;
    #0.5;
    chk(result_o == 32'hF800_0000, "R10", result_o, 32'hF800_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule